// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block chooses how one USB 2.0 device endpoint answers each token from the host. A token arrives as a single-cycle strobe carrying its kind (OUT, IN or PING). The block combines it with the endpoint kind (control, interrupt or bulk), the number of bytes now held in the endpoint FIFO, the maximum packet size and two application control bits. One is a sticky request to send a zero-length packet. The other is the interrupt-pending bit of an interrupt endpoint.

One clock later the block raises a one-cycle response strobe with an encoded response: data, zero-length data, ACK, NAK or NYET. For OUT tokens it also tells the receive path whether to keep the payload. For OUT and PING it compares the free FIFO space against one and two maximum packet sizes. For IN it gives the zero-length request priority over any data in the FIFO. On the control endpoint it clears that request itself once the zero-length packet has gone out. Serialization, CRC, data toggling and the FIFO storage are handled by neighbouring logic.

Top module: `usb_ep_handshake`

Encodings used throughout:
- Token kind: 00 OUT, 01 IN, 10 PING, 11 reserved.
- Endpoint kind: 00 control, 01 interrupt, 10 bulk; 11 behaves as bulk.
- Response code: 000 none, 001 data, 010 zero-length data, 011 ACK, 100 NAK, 101 NYET.
- Free space is FIFO_DEPTH minus the fill count, and is taken as zero if the count reaches the depth.

## Requirements
- R1: An OUT token is answered with NYET (101) when the FIFO already holds at least one byte, the free space is at least one maximum packet size, and the free space is less than twice the maximum packet size.
- R2: A PING token is answered with NAK (100) when the free space is less than one maximum packet size, and with ACK (011) otherwise.
- R3: While the zero-length flag is set, an IN token is answered with zero-length data (010) on every endpoint kind, whatever the FIFO holds and whatever the interrupt-pending bit is.
- R4: On a non-control endpoint (kind 01, 10 or 11), sending a zero-length packet leaves the flag set, so later IN tokens again get 010 until software clears the flag.
- R5: On the control endpoint (kind 00), the flag reads 0 in the cycle after the response strobe that carried a zero-length packet.
- R6: On an interrupt endpoint with the flag clear and interrupt-pending low, an IN token is answered with NAK (100).
- R7: On an interrupt endpoint with the flag clear and interrupt-pending high, an IN token is answered with data (001) when the FIFO count is non-zero, and with NAK (100) when the count is zero.
- R8: An OUT token with less than one maximum packet size free is answered with NAK (100), and the store output stays low so that the payload is dropped.
- R9: An OUT token for which neither R1 nor R8 applies is answered with ACK (011). The store output is high with both ACK and NYET on OUT.
- R10: On a control or bulk endpoint with the flag clear, an IN token is answered with data (001) when the FIFO count is non-zero, and with NAK (100) when it is zero.
- R11: After reset the response strobe, the response code, the store output and the flag are all 0. A valid token of kind 00, 01 or 10 makes the strobe high for exactly the next cycle. The strobe stays low for a reserved token (11) and in idle cycles, and the code reads 000 whenever the strobe is low.
- R12: A software write to the flag takes effect on the next cycle. When it falls in the same cycle as an automatic clear on the control endpoint, the software write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | One-cycle strobe: a token has arrived for this endpoint |
| tok_kind | input | 2 | Token kind: 00 OUT, 01 IN, 10 PING, 11 reserved |
| ep_kind | input | 2 | Endpoint kind: 00 control, 01 interrupt, 10 or 11 bulk |
| fifo_count | input | CNT_W | Bytes now held in the endpoint FIFO |
| max_pkt | input | MPS_W | Maximum packet size in bytes |
| int_pend | input | 1 | Interrupt-pending bit set by the application |
| txz_wr | input | 1 | Software write strobe for the zero-length flag |
| txz_wdata | input | 1 | Value written to the zero-length flag |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_code | output | 3 | Response code; 000 when the strobe is low |
| rx_store | output | 1 | High with the strobe when the OUT payload is to be kept |
| txz_flag | output | 1 | Current zero-length request flag |

## Verification
The bench builds the block with a 64-byte FIFO and a 7-bit maximum packet size, and draws packet sizes from 8 to 64 bytes. With these values every fill count from empty to full can be reached. Both free-space thresholds, and the case where twice the packet size is larger than the whole FIFO, come up often under random stimulus. Directed cases pin the exact threshold edges, the repeated zero-length answers on bulk and interrupt endpoints, and a software write that coincides with the automatic clear.

// File: rtl/usbhs_pkg.sv
package usbhs_pkg;
  typedef enum logic [1:0] {
    TOK_OUT  = 2'b00,
    TOK_IN   = 2'b01,
    TOK_PING = 2'b10,
    TOK_RSV  = 2'b11
  } tok_e;

  typedef enum logic [1:0] {
    EP_CTRL  = 2'b00,
    EP_INTR  = 2'b01,
    EP_BULK  = 2'b10,
    EP_BULKX = 2'b11
  } ep_e;

  typedef enum logic [2:0] {
    RSP_NONE = 3'd0,
    RSP_DATA = 3'd1,
    RSP_ZLP  = 3'd2,
    RSP_ACK  = 3'd3,
    RSP_NAK  = 3'd4,
    RSP_NYET = 3'd5
  } rsp_e;
endpackage

// File: rtl/hs_space_eval.sv
module hs_space_eval #(
  parameter int FIFO_DEPTH = 512,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int MPS_W      = 11
) (
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [MPS_W-1:0] max_pkt,
  output logic             below_one,
  output logic             below_two,
  output logic             has_data
);
  // Compare width covers both the depth and twice the packet size
  localparam int BASE_W = (CNT_W > MPS_W + 1) ? CNT_W : MPS_W + 1;
  localparam int CW     = BASE_W + 1;

  logic [CW-1:0] depth_w, count_w, free_w, one_w, two_w;

  always_comb begin
    depth_w = CW'(FIFO_DEPTH);
    count_w = CW'(fifo_count);
    free_w  = (count_w >= depth_w) ? '0 : depth_w - count_w;
    one_w   = CW'(max_pkt);
    two_w   = CW'(max_pkt) << 1;
  end

  assign below_one = free_w < one_w;
  assign below_two = free_w < two_w;
  assign has_data  = fifo_count != '0;
endmodule

// File: rtl/hs_zlp_flag.sv
module hs_zlp_flag (
  input  logic clk,
  input  logic rst,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic auto_clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (sw_wr)    flag <= sw_val;  // software has priority
    else if (auto_clr) flag <= 1'b0;
  end

  // R12: a write lands on the next cycle regardless of the clear
  p_sw_wins_r12: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> flag == $past(sw_val));
endmodule

// File: rtl/hs_decide.sv
module hs_decide
  import usbhs_pkg::*;
(
  input  tok_e  tok,
  input  ep_e   ep,
  input  logic  zlp_req,
  input  logic  int_pend,
  input  logic  below_one,
  input  logic  below_two,
  input  logic  has_data,
  output rsp_e  code,
  output logic  store
);
  always_comb begin
    code  = RSP_NONE;
    store = 1'b0;
    unique case (tok)
      TOK_OUT: begin
        if (below_one) begin
          code = RSP_NAK;
        end else if (has_data && below_two) begin
          code  = RSP_NYET;
          store = 1'b1;
        end else begin
          code  = RSP_ACK;
          store = 1'b1;
        end
      end
      TOK_PING: code = below_one ? RSP_NAK : RSP_ACK;
      TOK_IN: begin
        if (zlp_req)                       code = RSP_ZLP;
        else if (ep == EP_INTR && !int_pend) code = RSP_NAK;
        else if (has_data)                 code = RSP_DATA;
        else                               code = RSP_NAK;
      end
      default: code = RSP_NONE;
    endcase
  end
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usbhs_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int MPS_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic [1:0]       ep_kind,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             int_pend,
  input  logic             txz_wr,
  input  logic             txz_wdata,
  output logic             resp_valid,
  output logic [2:0]       resp_code,
  output logic             rx_store,
  output logic             txz_flag
);
  tok_e tok;
  ep_e  ep;
  logic below_one, below_two, has_data;
  rsp_e next_code;
  logic next_store;
  logic tok_ok, auto_clr;

  assign tok    = tok_e'(tok_kind);
  assign ep     = ep_e'(ep_kind);
  assign tok_ok = tok_valid && (tok != TOK_RSV);

  hs_space_eval #(
    .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .MPS_W(MPS_W)
  ) i_space (
    .fifo_count(fifo_count), .max_pkt(max_pkt),
    .below_one(below_one), .below_two(below_two), .has_data(has_data)
  );

  hs_decide i_decide (
    .tok(tok), .ep(ep), .zlp_req(txz_flag), .int_pend(int_pend),
    .below_one(below_one), .below_two(below_two), .has_data(has_data),
    .code(next_code), .store(next_store)
  );

  assign auto_clr = tok_ok && (next_code == RSP_ZLP) && (ep == EP_CTRL);

  hs_zlp_flag i_flag (
    .clk(clk), .rst(rst), .sw_wr(txz_wr), .sw_val(txz_wdata),
    .auto_clr(auto_clr), .flag(txz_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_code  <= RSP_NONE;
      rx_store   <= 1'b0;
    end else begin
      resp_valid <= tok_ok;
      resp_code  <= tok_ok ? next_code : RSP_NONE;
      rx_store   <= tok_ok && next_store;
    end
  end

  // R11: one strobe per accepted token, silence otherwise
  p_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind != 2'b11) |=> resp_valid);
  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !(tok_valid && tok_kind != 2'b11) |=> (!resp_valid && resp_code == 3'd0));
  // R2: a PING never gets anything but ACK or NAK
  p_ping_r2: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'b10) |=> (resp_code == 3'd3 || resp_code == 3'd4));
  // R1: NYET only when the FIFO already held data
  p_nyet_r1: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'b00 && fifo_count == '0) |=> resp_code != 3'd5);
  // R3: a pending zero-length request wins over data
  p_zlp_prio_r3: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'b01 && txz_flag) |=> resp_code == 3'd2);
  // R4: flag survives on non-control endpoints
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'b01 && txz_flag && ep_kind != 2'b00 && !txz_wr)
      |=> txz_flag);
  // R5: control endpoint clears the flag after sending
  p_ctrl_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'b01 && txz_flag && ep_kind == 2'b00 && !txz_wr)
      |=> !txz_flag);
  // R8: a NAK on OUT never stores
  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code == 3'd4) |-> !rx_store);
endmodule

// File: tb/test_usb_ep_handshake.sv
module test_usb_ep_handshake;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int MPS_W  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'b00, ep_kind = 2'b00;
  logic [CNT_W-1:0] fifo_count = '0;
  logic [MPS_W-1:0] max_pkt = 7'd8;
  logic int_pend = 1'b0, txz_wr = 1'b0, txz_wdata = 1'b0;
  logic resp_valid, rx_store, txz_flag;
  logic [2:0] resp_code;

  int total = 0;
  int bad = 0;
  bit model_txz = 1'b0;
  bit done = 1'b0;

  usb_ep_handshake #(.FIFO_DEPTH(DEPTH), .CNT_W(CNT_W), .MPS_W(MPS_W)) i_usb_ep_handshake (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .ep_kind(ep_kind), .fifo_count(fifo_count), .max_pkt(max_pkt),
    .int_pend(int_pend), .txz_wr(txz_wr), .txz_wdata(txz_wdata),
    .resp_valid(resp_valid), .resp_code(resp_code), .rx_store(rx_store),
    .txz_flag(txz_flag)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int free_of(int cnt);
    return (cnt >= DEPTH) ? 0 : DEPTH - cnt;
  endfunction

  function automatic int exp_code(int tk, int ep, int cnt, int mp, bit ip, bit z);
    int fr;
    fr = free_of(cnt);
    case (tk)
      0: begin
        if (fr < mp)                    return 4;
        else if (cnt != 0 && fr < 2*mp) return 5;
        else                            return 3;
      end
      2: return (fr < mp) ? 4 : 3;
      1: begin
        if (z)                 return 2;
        if (ep == 1 && !ip)    return 4;
        return (cnt != 0) ? 1 : 4;
      end
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int tk, int ep, int cnt, int mp, bit ip, bit z);
    int c;
    c = exp_code(tk, ep, cnt, mp, ip, z);
    if (tk == 3) return "R11";
    if (tk == 2) return "R2";
    if (tk == 0) return (c == 5) ? "R1" : (c == 4) ? "R8" : "R9";
    if (z)       return (ep == 0) ? "R5" : "R4";
    if (ep == 1) return ip ? "R7" : "R6";
    return "R10";
  endfunction

  // Drive one token at a negedge, check the response at the next negedge
  task automatic token(int tk, int ep, int cnt, int mp, bit ip, bit wr, bit wd);
    int ec;
    string tg;
    ec = exp_code(tk, ep, cnt, mp, ip, model_txz);
    tg = tag_of(tk, ep, cnt, mp, ip, model_txz);
    tok_valid  = 1'b1;
    tok_kind   = tk[1:0];
    ep_kind    = ep[1:0];
    fifo_count = CNT_W'(cnt);
    max_pkt    = MPS_W'(mp);
    int_pend   = ip;
    txz_wr     = wr;
    txz_wdata  = wd;
    @(negedge clk);
    tok_valid = 1'b0;
    txz_wr    = 1'b0;
    check({tg, " strobe"}, int'(resp_valid), (tk != 3) ? 1 : 0);
    check({tg, " code"}, int'(resp_code), ec);
    check({tg, " store"}, int'(rx_store), (tk == 0 && (ec == 3 || ec == 5)) ? 1 : 0);
    if (wr) model_txz = wd;
    else if (tk == 1 && ec == 2 && ep == 0) model_txz = 1'b0;
    check(wr ? "R12 flag" : (tk == 1 && ec == 2) ? {tg, " flag"} : "R11 flag",
          int'(txz_flag), int'(model_txz));
  endtask

  task automatic set_flag(bit v);
    txz_wr = 1'b1;
    txz_wdata = v;
    @(negedge clk);
    txz_wr = 1'b0;
    model_txz = v;
    check("R12 write", int'(txz_flag), int'(v));
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 reset strobe", int'(resp_valid), 0);
    check("R11 reset code", int'(resp_code), 0);
    check("R11 reset store", int'(rx_store), 0);
    check("R11 reset flag", int'(txz_flag), 0);

    // R1/R9 thresholds: depth 64, packet 32
    token(0, 2, 0, 32, 0, 0, 0);   // R9 empty, free 64
    token(0, 2, 1, 32, 0, 0, 0);   // R1 free 63 < 64
    token(0, 2, 32, 32, 0, 0, 0);  // R1 free 32, edge of one
    token(0, 2, 33, 32, 0, 0, 0);  // R8 free 31
    token(0, 2, 64, 8, 0, 0, 0);   // R8 full
    token(0, 2, 48, 8, 0, 0, 0);   // R9 free 16 == 2*8
    token(0, 2, 49, 8, 0, 0, 0);   // R1 free 15
    // R2 PING edges
    token(2, 2, 32, 32, 0, 0, 0);  // ACK at exactly one packet free
    token(2, 2, 33, 32, 0, 0, 0);  // NAK
    // R10 / R6 / R7
    token(1, 2, 0, 8, 0, 0, 0);
    token(1, 0, 5, 8, 0, 0, 0);
    token(1, 1, 5, 8, 0, 0, 0);
    token(1, 1, 5, 8, 1, 0, 0);
    token(1, 1, 0, 8, 1, 0, 0);
    // R11 idle and reserved
    @(negedge clk);
    check("R11 idle strobe", int'(resp_valid), 0);
    token(3, 2, 5, 8, 0, 0, 0);
    // R3/R4 repeated zero-length on bulk and interrupt
    set_flag(1'b1);
    token(1, 2, 20, 8, 0, 0, 0);
    token(1, 2, 20, 8, 0, 0, 0);
    token(1, 1, 20, 8, 0, 0, 0);
    set_flag(1'b0);
    token(1, 2, 20, 8, 0, 0, 0);
    // R5 control auto-clear
    set_flag(1'b1);
    token(1, 0, 20, 8, 1, 0, 0);
    token(1, 0, 20, 8, 1, 0, 0);
    // R12 software write beats auto-clear
    set_flag(1'b1);
    token(1, 0, 0, 8, 0, 1, 1);
    token(1, 0, 0, 8, 0, 0, 0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int tk, ep, cnt, mp;
      bit ip, wr, wd;
      tk  = $urandom_range(0, 3);
      ep  = $urandom_range(0, 3);
      cnt = $urandom_range(0, DEPTH);
      mp  = $urandom_range(8, 64);
      ip  = 1'($urandom_range(0, 1));
      wr  = ($urandom_range(0, 7) == 0);
      wd  = 1'($urandom_range(0, 1));
      token(tk, ep, cnt, mp, ip, wr, wd);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        check("R11 gap strobe", int'(resp_valid), 0);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule